// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a simple single-beat host port and an asynchronous byte-wide dynamic RAM of 524,288 locations. It splits each 19-bit host address into a 10-bit row and a 9-bit column and places them one after the other on a shared 10-pin address bus. It drives the row strobe, column strobe, write enable and output enable itself. Every strobe edge waits for its own cycle counter to reach the matching timing limit. All limits are parameters in clock cycles, rounded up from nanoseconds.

After an access the row stays open. A later request to the same row skips activation and only pulses the column strobe (page hit). A request to another row closes the open row, waits out precharge and activates the new row (page miss). The row also closes before the maximum row-strobe low time runs out, and when the refresh requester asks for a slot. Writes use early-write timing, so the memory never drives the data bus during a write. Reads capture the data bus only once three limits have all elapsed: access from the column strobe, access from the column address, and access from the end of the previous column precharge.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The row address `addr[18:10+... ]`, that is `addr[18:9]`, is on `dram_a[9:0]` when `dram_ras_n` falls. The column `addr[8:0]` is on `dram_a[8:0]`, with `dram_a[9]` at 0, when `dram_cas_n` falls, and `dram_a` is stable while `dram_cas_n` is low.
- R2: `dram_cas_n` falls only when `dram_ras_n` has been low for at least `T_RCD` cycles.
- R3: `dram_ras_n` stays low for at least `T_RAS` cycles and stays high for at least `T_RP` cycles before it falls again.
- R4: `dram_ras_n` never stays low for more than `T_RASMAX` cycles, even when the host is idle with a row open.
- R5: Between two column accesses, `dram_cas_n` stays high for at least `T_CP` cycles, and successive falls of `dram_cas_n` are at least `T_PC` cycles apart.
- R6: A request whose row equals the open row is served without a new row activation (no rise of `dram_ras_n`).
- R7: A request to a different row raises `dram_ras_n`, waits precharge and activates the new row, which then holds the written data.
- R8: On a write, `dram_we_n` is low before `dram_cas_n` falls, `dram_oe_n` stays high, and `dram_dq_o` carries `wdata` with `dram_dq_oe` = 1.
- R9: A read returns, on `rdata` with a one-cycle `rvalid` pulse, the byte that the memory drives once `T_CAC`, `T_AA` and `T_CPA` have all elapsed.
- R10: While `ref_req` is high, `ready` is low. An access already accepted completes before `ref_gnt` rises. `ref_gnt` is high only while both strobes are high, and it stays high until `ref_req` falls.
- R11: A request is accepted on a rising edge where `req` and `ready` are both 1. `ready` is 0 in the cycle after an acceptance.
- R12: During reset all four strobes are high, `dram_dq_oe`, `ready`, `rvalid` and `ref_gnt` are 0, and `ready` rises within `T_RP` plus a few cycles after reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request valid |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 19 | Host byte address, row in upper 10 bits |
| wdata | input | 8 | Write data |
| ready | output | 1 | Controller can accept a request this cycle |
| rvalid | output | 1 | One-cycle pulse: `rdata` holds read data |
| rdata | output | 8 | Read data |
| ref_req | input | 1 | Refresh slot requested |
| ref_gnt | output | 1 | Refresh slot granted, memory idle |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_a | output | 10 | Multiplexed row/column address |
| dram_dq_o | output | 8 | Data toward the memory |
| dram_dq_oe | output | 1 | Enable for the data driver toward the memory |
| dram_dq_i | input | 8 | Data from the memory |

## Verification
The bench builds the controller with the 5 ns clock values (`T_RCD`=4, `T_RAH`=2, `T_RAS`=12, `T_RP`=8, `T_CAC`=3, `T_AA`=6, `T_CPA`=7, `T_CP`=2, `T_PC`=8, `T_CAS`=2), so every strobe limit spans several cycles and a wrong comparison shows up as a one-cycle shift. `T_RASMAX` is cut from 20,000 to 200 cycles. With that value, a row left open by an idle host is forced shut within a few hundred cycles, while a page-hit sequence of four accesses still fits inside one row-open window. The bench's memory model drives valid data only after all three access limits. A read sampled too early therefore returns a marker byte instead of the stored one.

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int ROW_W    = 10,
  parameter int COL_W    = 9,
  parameter int DW       = 8,
  parameter int T_RCD    = 4,
  parameter int T_RAH    = 2,
  parameter int T_RAS    = 12,
  parameter int T_RASMAX = 20000,
  parameter int T_RP     = 8,
  parameter int T_CAC    = 3,
  parameter int T_AA     = 6,
  parameter int T_CPA    = 7,
  parameter int T_CP     = 2,
  parameter int T_PC     = 8,
  parameter int T_CAS    = 2,
  localparam int AW      = ROW_W + COL_W,
  localparam int MA      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic          rvalid,
  output logic [DW-1:0] rdata,
  input  logic          ref_req,
  output logic          ref_gnt,
  output logic          dram_ras_n,
  output logic          dram_cas_n,
  output logic          dram_we_n,
  output logic          dram_oe_n,
  output logic [MA-1:0] dram_a,
  output logic [DW-1:0] dram_dq_o,
  output logic          dram_dq_oe,
  input  logic [DW-1:0] dram_dq_i
);
  localparam int CW    = $clog2(T_RASMAX + 2);
  localparam int GUARD = T_PC + T_CPA + T_AA + T_CAC + T_CAS + 4;
  localparam logic [CW-1:0] K_SAT = CW'(T_RASMAX + 1);
  localparam logic [CW-1:0] K_LIM = CW'(T_RASMAX - GUARD);
  localparam logic [CW-1:0] K_RCD = CW'(T_RCD);
  localparam logic [CW-1:0] K_RAH = CW'(T_RAH);
  localparam logic [CW-1:0] K_RAS = CW'(T_RAS);
  localparam logic [CW-1:0] K_RP  = CW'(T_RP);
  localparam logic [CW-1:0] K_CAC = CW'(T_CAC);
  localparam logic [CW-1:0] K_AA  = CW'(T_AA);
  localparam logic [CW-1:0] K_CPA = CW'(T_CPA);
  localparam logic [CW-1:0] K_CP  = CW'(T_CP);
  localparam logic [CW-1:0] K_PC  = CW'(T_PC);
  localparam logic [CW-1:0] K_CAS = CW'(T_CAS);

  typedef enum logic [2:0] {S_PRE, S_IDLE, S_ACT, S_COL, S_CAS, S_OPEN, S_CLOSE, S_REF} st_t;

  st_t st, st_d;
  logic ras_d, cas_d, we_d, oe_d, dqoe_d, pend, pend_d, rvalid_d, col_load, wr_q;
  logic [MA-1:0]    a_d;
  logic [DW-1:0]    rdata_d;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [CW-1:0]    ras_lo, ras_hi, cas_lo, cas_hi, aa_c;

  wire [ROW_W-1:0] h_row = addr[AW-1:COL_W];
  wire [COL_W-1:0] h_col = addr[COL_W-1:0];
  wire acc = req && ready;

  assign ready   = ((st == S_IDLE) || (st == S_OPEN && ras_lo < K_LIM)) && !ref_req;
  assign ref_gnt = (st == S_REF);

  function automatic logic [CW-1:0] inc(input logic [CW-1:0] v);
    return (v == K_SAT) ? v : v + 1'b1;
  endfunction

  always_comb begin
    st_d = st; ras_d = dram_ras_n; cas_d = dram_cas_n; we_d = dram_we_n;
    oe_d = dram_oe_n; dqoe_d = dram_dq_oe; a_d = dram_a; pend_d = pend;
    rvalid_d = 1'b0; rdata_d = rdata; col_load = 1'b0;
    case (st)
      S_PRE: if (ras_hi >= K_RP) begin
        if (pend) begin
          ras_d = 1'b0; a_d = MA'(row_q); pend_d = 1'b0; st_d = S_ACT;
        end else if (ref_req) st_d = S_REF;
        else st_d = S_IDLE;
      end
      S_IDLE: if (ref_req) st_d = S_REF;
        else if (acc) begin
          ras_d = 1'b0; a_d = MA'(h_row); st_d = S_ACT;
        end
      S_ACT: if (ras_lo >= K_RAH) begin
        a_d = MA'(col_q); col_load = 1'b1;
        we_d = !wr_q; oe_d = wr_q; dqoe_d = wr_q; st_d = S_COL;
      end
      S_COL: if (ras_lo >= K_RCD && cas_hi >= K_CP && cas_lo >= K_PC) begin
        cas_d = 1'b0; st_d = S_CAS;
      end
      S_CAS: if (wr_q) begin
        if (cas_lo >= K_CAS) begin
          cas_d = 1'b1; we_d = 1'b1; dqoe_d = 1'b0; st_d = S_OPEN;
        end
      end else if (cas_lo >= K_CAC && aa_c >= K_AA && cas_hi >= K_CPA) begin
        rdata_d = dram_dq_i; rvalid_d = 1'b1; cas_d = 1'b1; oe_d = 1'b1; st_d = S_OPEN;
      end
      S_OPEN: if (ref_req || ras_lo >= K_LIM) st_d = S_CLOSE;
        else if (acc) begin
          if (h_row == row_q) begin
            a_d = MA'(h_col); col_load = 1'b1;
            we_d = !we; oe_d = we; dqoe_d = we; st_d = S_COL;
          end else begin
            pend_d = 1'b1; st_d = S_CLOSE;
          end
        end
      S_CLOSE: if (ras_lo >= K_RAS) begin
        ras_d = 1'b1; st_d = S_PRE;
      end
      S_REF: if (!ref_req) st_d = S_PRE;
      default: st_d = S_PRE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_PRE; pend <= 1'b0; wr_q <= 1'b0; row_q <= '0; col_q <= '0;
      dram_ras_n <= 1'b1; dram_cas_n <= 1'b1; dram_we_n <= 1'b1; dram_oe_n <= 1'b1;
      dram_a <= '0; dram_dq_o <= '0; dram_dq_oe <= 1'b0; rvalid <= 1'b0; rdata <= '0;
      ras_lo <= K_SAT; ras_hi <= '0; cas_lo <= K_SAT; cas_hi <= K_SAT; aa_c <= K_SAT;
    end else begin
      st <= st_d; pend <= pend_d;
      dram_ras_n <= ras_d; dram_cas_n <= cas_d; dram_we_n <= we_d; dram_oe_n <= oe_d;
      dram_a <= a_d; dram_dq_oe <= dqoe_d; rvalid <= rvalid_d; rdata <= rdata_d;
      if (acc) begin
        row_q <= h_row; col_q <= h_col; wr_q <= we; dram_dq_o <= wdata;
      end
      ras_lo <= (dram_ras_n && !ras_d) ? CW'(1) : inc(ras_lo);
      ras_hi <= ((!dram_ras_n && ras_d) || st == S_REF) ? CW'(1) : inc(ras_hi);
      cas_lo <= (dram_cas_n && !cas_d) ? CW'(1) : inc(cas_lo);
      cas_hi <= (!dram_cas_n && cas_d) ? CW'(1) : inc(cas_hi);
      aa_c   <= col_load ? CW'(1) : inc(aa_c);
    end
  end
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int MA       = 10,
  parameter int T_RCD    = 4,
  parameter int T_RAS    = 12,
  parameter int T_RASMAX = 20000,
  parameter int T_RP     = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          dq_oe,
  input logic          rvalid,
  input logic          ref_req,
  input logic          ref_gnt,
  input logic          ready,
  input logic [MA-1:0] a
);
  localparam int CW = $clog2(T_RASMAX + 2) + 1;
  localparam logic [CW-1:0] SAT = CW'(T_RASMAX + 2);
  logic [CW-1:0] lo, hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0; hi <= '0;
    end else begin
      lo <= ras_n ? '0 : ((lo == SAT) ? lo : lo + 1'b1);
      hi <= !ras_n ? '0 : ((hi == SAT) ? hi : hi + 1'b1);
    end
  end

  p_col_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(a));
  p_rcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> (lo >= CW'(T_RCD)));
  p_ras_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo >= CW'(T_RAS)));
  p_precharge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi >= CW'(T_RP)));
  p_ras_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lo <= CW'(T_RASMAX));
  p_early_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> (oe_n && dq_oe && $past(!we_n)));
  p_rvalid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);
  p_gnt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (ras_n && cas_n));
  p_no_accept_ref_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !ready);
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
  .MA(MA), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RASMAX(T_RASMAX), .T_RP(T_RP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe), .rvalid(rvalid),
  .ref_req(ref_req), .ref_gnt(ref_gnt), .ready(ready), .a(dram_a)
);

// File: tb/fpm_dram_ctrl_bench.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_bench;
  localparam int T_RCD = 4, T_RAH = 2, T_RAS = 12, T_RASMAX = 200, T_RP = 8;
  localparam int T_CAC = 3, T_AA = 6, T_CPA = 7, T_CP = 2, T_PC = 8, T_CAS = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, ref_req = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0, rdata, dram_dq_o, dram_dq_i = 8'hEE;
  logic ready, rvalid, ref_gnt, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [9:0] dram_a;

  fpm_dram_ctrl #(.T_RCD(T_RCD), .T_RAH(T_RAH), .T_RAS(T_RAS), .T_RASMAX(T_RASMAX),
    .T_RP(T_RP), .T_CAC(T_CAC), .T_AA(T_AA), .T_CPA(T_CPA), .T_CP(T_CP), .T_PC(T_PC),
    .T_CAS(T_CAS)) u_fpm_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .rvalid(rvalid), .rdata(rdata), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_a(dram_a), .dram_dq_o(dram_dq_o),
    .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  int n_fall = 0, n_rise = 0;
  logic [7:0] mem [int unsigned];
  logic [7:0] shadow [int unsigned];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 40000) begin
      chk(1'b0, "watchdog", cyc, 40000);
      finish_run();
    end
  end

  // memory model and strobe timing monitor, sampled mid-cycle
  logic ras_p = 1'b1, cas_p = 1'b1, have_cas = 1'b0, m_pin9 = 1'b0;
  logic [9:0] a_p = '0, m_row = '0;
  logic [8:0] m_col = '0;
  int t_rfall = 0, t_rrise = 0, t_cfall = 0, t_crise = 0;
  int mc_cas = 0, mc_aa = 0, mc_cpa = 1000;

  function automatic logic [7:0] rd_mem(input int unsigned k);
    return mem.exists(k) ? mem[k] : 8'h00;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (ras_p && !dram_ras_n) begin
        n_fall++;
        chk(cyc - t_rrise >= T_RP, "R3 precharge", cyc - t_rrise, T_RP);
        m_row = dram_a; t_rfall = cyc;
      end
      if (!ras_p && dram_ras_n) begin
        n_rise++;
        chk(cyc - t_rfall >= T_RAS, "R3 ras low min", cyc - t_rfall, T_RAS);
        chk(cyc - t_rfall <= T_RASMAX, "R4 ras low max", cyc - t_rfall, T_RASMAX);
        t_rrise = cyc;
      end
      if (cas_p && !dram_cas_n) begin
        chk(cyc - t_rfall >= T_RCD, "R2 ras to cas", cyc - t_rfall, T_RCD);
        if (have_cas) begin
          chk(cyc - t_crise >= T_CP, "R5 cas precharge", cyc - t_crise, T_CP);
          chk(cyc - t_cfall >= T_PC, "R5 page cycle", cyc - t_cfall, T_PC);
        end
        have_cas = 1'b1; t_cfall = cyc;
        m_col = dram_a[8:0]; m_pin9 = dram_a[9];
        if (!dram_we_n) begin
          chk(dram_oe_n && dram_dq_oe, "R8 oe high, dq driven", {dram_oe_n, dram_dq_oe}, 3);
          mem[{m_row, dram_a[8:0]}] = dram_dq_o;
        end
      end
      if (!cas_p && dram_cas_n) t_crise = cyc;
      mc_cas = dram_cas_n ? 0 : (cas_p ? 1 : mc_cas + 1);
      mc_aa  = (dram_a != a_p) ? 1 : ((mc_aa < 1000) ? mc_aa + 1 : mc_aa);
      mc_cpa = (dram_cas_n && !cas_p) ? 1 : ((mc_cpa < 1000) ? mc_cpa + 1 : mc_cpa);
      if (!dram_cas_n && !dram_oe_n && dram_we_n &&
          mc_cas >= T_CAC && mc_aa >= T_AA && mc_cpa >= T_CPA)
        dram_dq_i = rd_mem({m_row, dram_a[8:0]});
      else
        dram_dq_i = 8'hEE;
    end
    ras_p = dram_ras_n; cas_p = dram_cas_n; a_p = dram_a;
  end

  task automatic issue(input logic w, input logic [18:0] ad, input logic [7:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; we = w; addr = ad; wdata = d;
    @(negedge clk);
    req = 1'b0;
    chk(!ready, "R11 ready low after accept", ready, 0);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 400 && !ready; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [18:0] ad, input logic [7:0] d);
    issue(1'b1, ad, d);
    shadow[ad] = d;
    wait_ready();
    chk(rd_mem(ad) == d, "R8 write stored", rd_mem(ad), d);
    chk(m_row == ad[18:9], "R1 row on pins", m_row, ad[18:9]);
    chk(m_col == ad[8:0] && !m_pin9, "R1 column on pins", {m_pin9, m_col}, ad[8:0]);
  endtask

  task automatic do_read(input logic [18:0] ad);
    logic [7:0] exp;
    bit got;
    exp = shadow.exists(ad) ? shadow[ad] : 8'h00;
    got = 1'b0;
    issue(1'b0, ad, 8'h00);
    for (int i = 0; i < 100 && !got; i++) begin
      if (rvalid) got = 1'b1; else @(negedge clk);
    end
    chk(got, "R9 rvalid seen", got, 1);
    chk(rdata == exp, "R9 read data", rdata, exp);
    chk(m_row == ad[18:9] && m_col == ad[8:0], "R1 read address", {m_row, m_col}, ad);
    @(negedge clk);
    chk(!rvalid, "R9 rvalid single pulse", rvalid, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R12 strobes high",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    chk(!dram_dq_oe && !ready && !rvalid && !ref_gnt, "R12 outputs low",
        {dram_dq_oe, ready, rvalid, ref_gnt}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < T_RP + 4 && !ready; i++) @(negedge clk);
    chk(ready, "R12 ready after reset", ready, 1);
  endtask

  task automatic t_single();
    do_write(19'h12345, 8'hA5);
    do_read(19'h12345);
  endtask

  task automatic t_page_hits();
    int f0, r0;
    do_write({10'h155, 9'h003}, 8'h31);
    f0 = n_fall; r0 = n_rise;
    do_write({10'h155, 9'h1FF}, 8'hC7);
    do_read({10'h155, 9'h003});
    do_read({10'h155, 9'h1FF});
    chk(n_fall == f0 && n_rise == r0, "R6 no reactivation on hits", n_fall - f0, 0);
  endtask

  task automatic t_page_miss();
    int f0, r0;
    f0 = n_fall; r0 = n_rise;
    do_write({10'h2AA, 9'h0F7}, 8'h5C);
    chk(n_rise == r0 + 1 && n_fall == f0 + 1, "R7 close and reopen", n_fall - f0, 1);
    do_read({10'h155, 9'h1FF});
    do_read({10'h2AA, 9'h0F7});
  endtask

  task automatic t_rasmax();
    int r0;
    do_read({10'h0C3, 9'h010});
    r0 = n_rise;
    repeat (T_RASMAX + 20) @(negedge clk);
    chk(dram_ras_n, "R4 idle row closed", dram_ras_n, 1);
    chk(n_rise == r0 + 1, "R4 one forced close", n_rise - r0, 1);
  endtask

  task automatic t_refresh_idle();
    do_write({10'h001, 9'h002}, 8'h9A);
    ref_req = 1'b1;
    #1;
    chk(!ready, "R10 ready low under refresh request", ready, 0);
    for (int i = 0; i < 100 && !ref_gnt; i++) @(negedge clk);
    chk(ref_gnt, "R10 grant given", ref_gnt, 1);
    repeat (5) @(negedge clk);
    chk(ref_gnt && dram_ras_n && dram_cas_n && !ready, "R10 grant held, strobes idle",
        {ref_gnt, dram_ras_n, dram_cas_n, ready}, 14);
    ref_req = 1'b0;
    @(negedge clk);
    chk(!ref_gnt, "R10 grant released", ref_gnt, 1'b0);
    do_read({10'h001, 9'h002});
  endtask

  task automatic t_refresh_inflight();
    bit got_rv, gnt_first;
    logic [7:0] rv_data;
    got_rv = 1'b0; gnt_first = 1'b0; rv_data = 8'h00;
    issue(1'b0, {10'h2AA, 9'h0F7}, 8'h00);
    ref_req = 1'b1;
    for (int i = 0; i < 200 && !ref_gnt; i++) begin
      if (rvalid) begin got_rv = 1'b1; rv_data = rdata; end
      @(negedge clk);
    end
    if (ref_gnt && !got_rv) gnt_first = 1'b1;
    chk(got_rv && !gnt_first, "R10 access finishes before grant", got_rv, 1);
    chk(rv_data == 8'h5C, "R9 read across refresh", rv_data, 8'h5C);
    chk(ref_gnt, "R10 grant after access", ref_gnt, 1);
    ref_req = 1'b0;
    do_write({10'h2AA, 9'h0F8}, 8'h07);
    do_read({10'h2AA, 9'h0F8});
  endtask

  initial begin
    t_reset();
    t_single();
    t_page_hits();
    t_page_miss();
    t_rasmax();
    t_refresh_idle();
    t_refresh_inflight();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule